// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a free-running interval timer that counts clock cycles on its own, without help from the processor. A primary divider turns the system clock into a base tick. A secondary divider can be switched in after it, which makes the timer's resolution coarser by the secondary ratio. An 8-bit final counter advances once per selected tick. When that counter equals an 8-bit limit value, the timer expires: the final counter restarts from zero and a sticky expired flag is set. If the interrupt enable is on, the expired flag drives an interrupt request toward the system's interrupt aggregator.

Software controls the timer through a single write strobe. One write loads the run, hold-clear, prescale-select and interrupt-enable bits together with the limit. The secondary and final counters are brought out as read-back values. The run and enable bits are also echoed as status. All pins are plain control and status signals. No data stream passes through the block, so there is no handshake and no back-pressure.

With the default ratios of 4000 and 100 on a 40 MHz clock, the resolution is 100 us with the prescaler off and 10 ms with it on. The longest timeout is 256 ticks.

Top module: `interval_timer`

## Requirements
- R1: After reset, the final and secondary chains read 0, the expired flag and `irq` are 0, and the run and interrupt-enable status bits are both 0 (the enable is cleared by reset).
- R2: With `ctl_prescale`=0 and the timer active (run=1, hold=0), the final chain advances by one every PRI_DIV clock cycles.
- R3: With `ctl_prescale`=1, the secondary chain counts 0..SEC_DIV-1 once per primary tick, and the final chain advances once every PRI_DIV*SEC_DIV cycles. With `ctl_prescale`=0, the secondary chain reads 0.
- R4: On the step taken while the final chain equals the limit, the final chain returns to 0 and the expired flag is set. The timeout is therefore (limit+1) ticks, and a limit of 255 gives 256 ticks.
- R5: The expired flag stays set until the hold-clear bit is written. Counting continues through expiry and repeats with the same period.
- R6: While the hold-clear bit is 1, all chains stay at 0 and the expired flag stays at 0, even with run=1.
- R7: With run=0 and hold-clear=0, the primary, secondary and final chains keep their values, and counting resumes from them when run returns to 1.
- R8: `irq` is 1 exactly when the expired flag and the interrupt enable are both 1. With the enable at 0, an expiry leaves `irq` at 0 while `sts_expired` is still set.
- R9: If the limit is written below the current final-chain value, no expiry occurs until the chain wraps from 255 to 0 and reaches the new limit.
- R10: A write (`ctl_we`=1) takes effect on the clock edge that samples it. The chains use the old settings on that edge and the new settings from the next edge on. `sts_running` and `sts_irq_en` echo the stored run and enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for all control fields |
| ctl_run | input | 1 | Run bit to store |
| ctl_clear | input | 1 | Hold-clear bit to store |
| ctl_prescale | input | 1 | 1 inserts the secondary divider |
| ctl_irq_en | input | 1 | Interrupt enable to store |
| ctl_limit | input | 8 | Expiry limit to store |
| sts_running | output | 1 | Stored run bit |
| sts_irq_en | output | 1 | Stored interrupt enable |
| sts_expired | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |
| sec_chain | output | SEC_W | Secondary chain value |
| fin_chain | output | 8 | Final chain value |

## Verification
The bench runs with small divider ratios so that whole timeout periods can be checked on every cycle. It sweeps limit values 0 through 15 and both extremes, with the prescaler on and off.

- An off-by-one in the equality compare or the restart would show up as a period of limit or limit+2 ticks.
- A secondary chain that is not bypassed would slow the final chain by a factor of SEC_DIV.
- Lowering the limit below the running count must not cause an expiry until the counter wraps. A design that compares with "greater or equal" would expire at once.
- Hold-clear is checked with run set. A freeze is checked in the middle of a count. An expiry with the interrupt enable off must leave `irq` low.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef struct packed {
    logic run;
    logic hold;
    logic pre;
    logic ien;
  } tmr_ctl_t;
endpackage

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
  import timer_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             run,
  input  logic             hold,
  input  logic             pre,
  input  logic             ien,
  input  logic [LIM_W-1:0] limit,
  output tmr_ctl_t         ctl_q,
  output logic [LIM_W-1:0] limit_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      limit_q <= '0;
    end else if (we) begin
      ctl_q.run  <= run;
      ctl_q.hold <= hold;
      ctl_q.pre  <= pre;
      ctl_q.ien  <= ien;
      limit_q    <= limit;
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRI_DIV = 4000,
  parameter int SEC_DIV = 100,
  parameter int SEC_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             advance,
  input  logic             pre_en,
  output logic [SEC_W-1:0] sec_q,
  output logic             step
);
  localparam int PRI_W = (PRI_DIV > 1) ? $clog2(PRI_DIV) : 1;

  logic [PRI_W-1:0] pri_q;
  logic             pri_tick;

  assign pri_tick = advance && (pri_q == PRI_W'(PRI_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      pri_q <= '0;
    end else if (advance) begin
      pri_q <= pri_tick ? '0 : pri_q + PRI_W'(1);
    end
  end

  generate
    if (SEC_DIV > 1) begin : g_sec
      logic sec_tick;
      assign sec_tick = pri_tick && (sec_q == SEC_W'(SEC_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || hold || !pre_en) begin
          sec_q <= '0;
        end else if (pri_tick) begin
          sec_q <= sec_tick ? '0 : sec_q + SEC_W'(1);
        end
      end
      assign step = pre_en ? sec_tick : pri_tick;
    end else begin : g_nosec
      assign sec_q = '0;
      assign step  = pri_tick;
    end
  endgenerate
endmodule

// File: rtl/tmr_final_stage.sv
module tmr_final_stage #(
  parameter int FIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             step,
  input  logic [FIN_W-1:0] limit,
  output logic [FIN_W-1:0] fin_q,
  output logic             expired_q
);
  logic hit;
  assign hit = step && (fin_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      fin_q     <= '0;
      expired_q <= 1'b0;
    end else if (step) begin
      if (hit) begin
        fin_q     <= '0;
        expired_q <= 1'b1;
      end else begin
        fin_q <= fin_q + FIN_W'(1);
      end
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter int PRI_DIV = 4000,
  parameter int SEC_DIV = 100,
  localparam int SEC_W = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1,
  localparam int FIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_run,
  input  logic             ctl_clear,
  input  logic             ctl_prescale,
  input  logic             ctl_irq_en,
  input  logic [FIN_W-1:0] ctl_limit,
  output logic             sts_running,
  output logic             sts_irq_en,
  output logic             sts_expired,
  output logic             irq,
  output logic [SEC_W-1:0] sec_chain,
  output logic [FIN_W-1:0] fin_chain
);
  tmr_ctl_t         ctl_q;
  logic [FIN_W-1:0] limit_q;
  logic             advance;
  logic             step;

  tmr_ctl_regs #(.LIM_W(FIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .run(ctl_run), .hold(ctl_clear),
    .pre(ctl_prescale), .ien(ctl_irq_en), .limit(ctl_limit),
    .ctl_q(ctl_q), .limit_q(limit_q)
  );

  assign advance = ctl_q.run && !ctl_q.hold;

  tmr_prescaler #(.PRI_DIV(PRI_DIV), .SEC_DIV(SEC_DIV), .SEC_W(SEC_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .hold(ctl_q.hold), .advance(advance),
    .pre_en(ctl_q.pre), .sec_q(sec_chain), .step(step)
  );

  tmr_final_stage #(.FIN_W(FIN_W)) u_fin (
    .clk(clk), .rst_n(rst_n), .hold(ctl_q.hold), .step(step),
    .limit(limit_q), .fin_q(fin_chain), .expired_q(sts_expired)
  );

  assign sts_running = ctl_q.run;
  assign sts_irq_en  = ctl_q.ien;
  assign irq         = sts_expired && ctl_q.ien;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int SEC_W = 7,
  parameter int FIN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic             pre,
  input logic             run,
  input logic             ien,
  input logic [FIN_W-1:0] limit,
  input logic [SEC_W-1:0] sec_chain,
  input logic [FIN_W-1:0] fin_chain,
  input logic             expired,
  input logic             irq
);
  // R6
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (fin_chain == '0) && (sec_chain == '0) && !expired);

  // R5
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !hold |=> expired);

  // R7
  frozen_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !hold |=> $stable(fin_chain));

  // R4
  expiry_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> (fin_chain == '0) && ($past(fin_chain) == $past(limit)));

  // R3
  sec_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pre |=> sec_chain == '0);

  // R2
  final_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_chain != $past(fin_chain) |->
      (fin_chain == $past(fin_chain) + FIN_W'(1)) || (fin_chain == '0));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> expired && ien);
endmodule

bind interval_timer interval_timer_chk #(.SEC_W(SEC_W), .FIN_W(FIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(ctl_q.hold), .pre(ctl_q.pre),
  .run(ctl_q.run), .ien(ctl_q.ien), .limit(limit_q),
  .sec_chain(sec_chain), .fin_chain(fin_chain), .expired(sts_expired), .irq(irq)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  localparam int P = 4;
  localparam int S = 3;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_run = 1'b0, ctl_clear = 1'b0, ctl_prescale = 1'b0, ctl_irq_en = 1'b0;
  logic [7:0] ctl_limit = '0;
  logic sts_running, sts_irq_en, sts_expired, irq;
  logic [SW-1:0] sec_chain;
  logic [7:0] fin_chain;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_p = 0, m_s = 0, m_f = 0;
  bit m_e = 0;
  bit c_run = 0, c_hold = 0, c_pre = 0, c_ien = 0;
  int c_lim = 0;

  always #2 clk = ~clk;

  interval_timer #(.PRI_DIV(P), .SEC_DIV(S)) u_interval_timer (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_run(ctl_run),
    .ctl_clear(ctl_clear), .ctl_prescale(ctl_prescale), .ctl_irq_en(ctl_irq_en),
    .ctl_limit(ctl_limit), .sts_running(sts_running), .sts_irq_en(sts_irq_en),
    .sts_expired(sts_expired), .irq(irq), .sec_chain(sec_chain), .fin_chain(fin_chain)
  );

  task automatic check(input string tag);
    bit exp_irq;
    exp_irq = m_e && c_ien;
    checks++;
    if (fin_chain != 8'(m_f) || sec_chain != SW'(m_s) || sts_expired != m_e ||
        irq != exp_irq || sts_running != c_run || sts_irq_en != c_ien) begin
      fails++;
      $display("FAIL %s: fin=%0d sec=%0d exp=%0d irq=%0d run=%0d ien=%0d expected fin=%0d sec=%0d exp=%0d irq=%0d run=%0d ien=%0d",
               tag, fin_chain, sec_chain, sts_expired, irq, sts_running, sts_irq_en,
               m_f, m_s, m_e, exp_irq, c_run, c_ien);
    end
  endtask

  task automatic tick(input bit we, input bit r, input bit h, input bit pr,
                      input bit ie, input int lim);
    bit ptk, stk, stp;
    ctl_we = we; ctl_run = r; ctl_clear = h; ctl_prescale = pr;
    ctl_irq_en = ie; ctl_limit = 8'(lim);
    @(posedge clk);
    if (c_hold) begin
      m_p = 0; m_s = 0; m_f = 0; m_e = 0;
    end else begin
      ptk = c_run && (m_p == P - 1);
      stk = ptk && (m_s == S - 1);
      if (c_run) m_p = ptk ? 0 : m_p + 1;
      if (!c_pre) m_s = 0;
      else if (ptk) m_s = stk ? 0 : m_s + 1;
      stp = c_pre ? stk : ptk;
      if (stp) begin
        if (m_f == c_lim) begin m_f = 0; m_e = 1; end
        else m_f = (m_f + 1) % 256;
      end
    end
    if (we) begin
      c_run = r; c_hold = h; c_pre = pr; c_ien = ie; c_lim = lim;
    end
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic run_for(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      tick(0, 0, 0, 0, 0, 0);
      check(tag);
    end
  endtask

  task automatic seg(input string tag, input bit pr, input bit ie, input int lim, input int n);
    tick(1, 0, 1, pr, ie, lim);
    check("R10");
    tick(1, 1, 0, pr, ie, lim);
    check("R10");
    run_for(tag, n);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1");
    tick(0, 0, 0, 0, 0, 0);
    check("R1");
    seg("R2", 0, 1, 1, 20);
    seg("R4", 0, 1, 0, 12);
    seg("R3", 1, 1, 2, 80);
    seg("R8", 0, 0, 255, 1030);
    seg("R4", 1, 1, 255, 3080);
    seg("R5", 0, 1, 3, 60);
    // R6: hold with run set
    tick(1, 1, 1, 1, 1, 0);
    check("R10");
    run_for("R6", 30);
    // R7: freeze mid-count, then resume
    seg("R7", 1, 1, 4, 19);
    tick(1, 0, 0, 1, 1, 4);
    check("R10");
    run_for("R7", 25);
    tick(1, 1, 0, 1, 1, 4);
    check("R10");
    run_for("R7", 90);
    // R9: lower limit below current count
    seg("R9", 0, 1, 10, 30);
    tick(1, 1, 0, 0, 1, 3);
    check("R10");
    run_for("R9", 260 * P);
    for (int t = 0; t < 16; t++) seg("R4", 0, 1, t, (t + 1) * P + 6);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule